// File: doc/BRIEF.md
# Interrupt Arbitration and Vectoring Unit

This unit decides which interrupt a processor core enters next and where that entry's address is stored. It watches three active-low request pins: a non-maskable request, a normal request and a fast request. It also takes a two-bit software-interrupt selector from the core. The pins pass through a synchronizer. Requests are judged only when the core raises its instruction-boundary strobe. At that point the unit applies the two mask bits of the condition-code value supplied by the core and picks one winner by fixed priority.

The winner is held on a request/acknowledge handshake until the core accepts it. The unit presents four things:
- the 16-bit address of the vector pair to fetch,
- a source code,
- a flag telling the core whether to stack the whole register set or only the minimal fast frame,
- the condition-code value with the winner's mask bits set, for the core to write back.

Reset is itself an entry. While reset is asserted, the unit presents the reset vector, and it keeps presenting it after reset is released until the core acknowledges it.

Top module: `irq_vector_unit`

## Requirements
- R1: During and after reset, until acknowledged, `take_valid` is 1, `take_src` is 0 (reset), `take_addr` is 16'hFFFE, `take_fast` is 0, and `take_cc` has bits 4 and 6 set with the other bits equal to `cc_in` at that time.
- R2: Each request pin passes through two flip-flops before arbitration. A pin driven low after clock edge N is not seen by a strobe sampled at edge N+1 or N+2. It is seen by a strobe sampled at edge N+3.
- R3: A new entry is latched only at a clock edge where `insn_bound` is 1 and `take_valid` is 0. Pending requests without the strobe leave `take_valid` at 0. If no source is eligible at the strobe, nothing is latched.
- R4: Priority from highest to lowest is: reset (code 0), non-maskable (1), software 1 (2), normal (3), fast (4), software 2 (5), software 3 (6). The lowest eligible code wins.
- R5: The normal request is eligible only when `cc_in[4]` is 0, and the fast request only when `cc_in[6]` is 0. The non-maskable request and the software selector ignore both bits.
- R6: `take_addr` is the even address of the winner's vector pair: FFFE reset, FFFC non-maskable, FFFA software 1, FFF8 normal, FFF6 fast, FFF4 software 2, FFF2 software 3.
- R7: `take_fast` is 1 only for a fast-request entry. Every other entry is a full entry.
- R8: `take_cc` equals `cc_in` at the strobe, with extra bits set as follows. A normal entry sets bit 4. Fast, non-maskable and software-1 entries set bits 4 and 6. Software-2 and software-3 entries set nothing. No bit is ever cleared.
- R9: While `take_valid` is 1 and `take_ack` is 0, all `take_*` outputs hold their values and strobes are ignored. When `take_ack` is 1 with `take_valid`, `take_valid` is 0 after that edge.
- R10: `swi_sel` encodes 2'b00 none, 2'b01 software 1, 2'b10 software 2, 2'b11 software 3. It is sampled only together with `insn_bound`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_req_n | input | 1 | Non-maskable request pin, active low |
| irq_req_n | input | 1 | Normal request pin, active low |
| firq_req_n | input | 1 | Fast request pin, active low |
| swi_sel | input | 2 | Software-interrupt selector from the core |
| insn_bound | input | 1 | Instruction-boundary strobe from the core |
| cc_in | input | 8 | Current condition-code value |
| take_ack | input | 1 | Core accepts the presented entry |
| take_valid | output | 1 | An entry is presented |
| take_src | output | 3 | Winning source code |
| take_addr | output | 16 | Even address of the vector pair |
| take_fast | output | 1 | 1 for fast stacking, 0 for full stacking |
| take_cc | output | 8 | Condition-code value to write back |

## Verification
The assertions assume that the core holds `take_ack` low except while an entry is presented, and that `swi_sel` and `cc_in` only matter in the cycle of the strobe. The priority and mask properties compare a freshly latched entry with the synchronized request vector and `cc_in` one cycle earlier. The stimulus keeps within these assumptions in four ways:
- pins are held steady for at least three cycles before any strobe, so the bench knows which value the synchronizer delivers;
- the selector and condition code are driven together with the strobe;
- the acknowledge is pulsed for one cycle only after an entry appears;
- extra strobes are deliberately issued while an entry is held, to exercise the rule that they are ignored.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;

  localparam int unsigned SRC_W     = 3;
  localparam int unsigned NUM_SRC   = 7;
  localparam int unsigned ADDR_W    = 16;
  localparam int unsigned CC_W      = 8;
  localparam int unsigned NORM_MASK = 4;
  localparam int unsigned FAST_MASK = 6;
  localparam logic [ADDR_W-1:0] VEC_TOP = 16'hFFFE;

  typedef enum logic [SRC_W-1:0] {
    SRC_RST  = 3'd0,
    SRC_NMI  = 3'd1,
    SRC_SW1  = 3'd2,
    SRC_NORM = 3'd3,
    SRC_FAST = 3'd4,
    SRC_SW2  = 3'd5,
    SRC_SW3  = 3'd6
  } src_e;

  // Vector pairs descend two bytes per priority step from the top.
  function automatic logic [ADDR_W-1:0] vec_addr(input src_e s);
    vec_addr = VEC_TOP - ADDR_W'({s, 1'b0});
  endfunction

  // True when the condition code blocks the given source.
  function automatic logic src_masked(input src_e s, input logic [CC_W-1:0] cc);
    case (s)
      SRC_NORM: src_masked = cc[NORM_MASK];
      SRC_FAST: src_masked = cc[FAST_MASK];
      default:  src_masked = 1'b0;
    endcase
  endfunction

  // Mask bits that taking the given entry sets.
  function automatic logic [CC_W-1:0] set_bits(input src_e s);
    logic [CC_W-1:0] m;
    m = '0;
    case (s)
      SRC_NORM: m[NORM_MASK] = 1'b1;
      SRC_RST, SRC_NMI, SRC_SW1, SRC_FAST: begin
        m[NORM_MASK] = 1'b1;
        m[FAST_MASK] = 1'b1;
      end
      default: m = '0;
    endcase
    set_bits = m;
  endfunction

  function automatic logic fast_entry(input src_e s);
    fast_entry = (s == SRC_FAST);
  endfunction

endpackage

// File: rtl/irq_vector_sync.sv
module irq_vector_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_n,
  output logic [WIDTH-1:0] req
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '1;
        else if (g == 0) stage_q[g] <= pin_n;
        else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign req = ~stage_q[STAGES-1];
endmodule

// File: rtl/irq_vector_pick.sv
module irq_vector_pick
  import irq_vector_pkg::*;
(
  input  logic [NUM_SRC-1:0] req_vec,
  input  logic [CC_W-1:0]    cc,
  output logic               win_any,
  output src_e               win_src
);
  logic [NUM_SRC-1:0] eligible;

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_elig
      assign eligible[g] = req_vec[g] && !src_masked(src_e'(g), cc);
    end
  endgenerate

  always_comb begin
    win_src = SRC_SW3;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (eligible[i]) win_src = src_e'(i);
    end
  end

  assign win_any = |eligible;
endmodule

// File: rtl/irq_vector_hold.sv
module irq_vector_hold
  import irq_vector_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              ack,
  input  src_e              src,
  input  logic [CC_W-1:0]   cc,
  output logic              valid,
  output src_e              src_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              fast_q,
  output logic [CC_W-1:0]   cc_q,
  input  logic [CC_W-1:0]   rst_cc
);
  logic in_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_rst <= 1'b1;
    else if (valid && ack) in_rst <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b1;
      src_q  <= SRC_RST;
      addr_q <= vec_addr(SRC_RST);
      fast_q <= 1'b0;
    end else if (valid && ack) begin
      valid <= 1'b0;
    end else if (load) begin
      valid  <= 1'b1;
      src_q  <= src;
      addr_q <= vec_addr(src);
      fast_q <= fast_entry(src);
    end
  end

  logic [CC_W-1:0] cc_reg;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cc_reg <= '0;
    else if (load && !valid) cc_reg <= cc | set_bits(src);
  end

  // The reset entry's write-back value follows cc_in until it is accepted.
  assign cc_q = in_rst ? (rst_cc | set_bits(SRC_RST)) : cc_reg;
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irq_vector_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_req_n,
  input  logic              irq_req_n,
  input  logic              firq_req_n,
  input  logic [1:0]        swi_sel,
  input  logic              insn_bound,
  input  logic [CC_W-1:0]   cc_in,
  input  logic              take_ack,
  output logic              take_valid,
  output logic [SRC_W-1:0]  take_src,
  output logic [ADDR_W-1:0] take_addr,
  output logic              take_fast,
  output logic [CC_W-1:0]   take_cc
);
  localparam int unsigned PINS = 3;

  logic [PINS-1:0]    pin_req;
  logic [NUM_SRC-1:0] req_vec;
  logic               win_any;
  src_e               win_src;
  logic               load_entry;
  src_e               held_src;

  irq_vector_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_n ({firq_req_n, irq_req_n, nmi_req_n}),
    .req   (pin_req)
  );

  always_comb begin
    req_vec           = '0;
    req_vec[SRC_NMI]  = pin_req[0];
    req_vec[SRC_NORM] = pin_req[1];
    req_vec[SRC_FAST] = pin_req[2];
    req_vec[SRC_SW1]  = (swi_sel == 2'b01);
    req_vec[SRC_SW2]  = (swi_sel == 2'b10);
    req_vec[SRC_SW3]  = (swi_sel == 2'b11);
  end

  irq_vector_pick u_pick (
    .req_vec (req_vec),
    .cc      (cc_in),
    .win_any (win_any),
    .win_src (win_src)
  );

  assign load_entry = insn_bound && win_any && !take_valid;

  irq_vector_hold u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load_entry),
    .ack    (take_ack),
    .src    (win_src),
    .cc     (cc_in),
    .valid  (take_valid),
    .src_q  (held_src),
    .addr_q (take_addr),
    .fast_q (take_fast),
    .cc_q   (take_cc),
    .rst_cc (cc_in)
  );

  assign take_src = held_src;
endmodule

// File: rtl/irq_vector_unit_chk.sv
module irq_vector_unit_chk
  import irq_vector_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              insn_bound,
  input logic [CC_W-1:0]   cc_in,
  input logic              take_ack,
  input logic              take_valid,
  input logic [SRC_W-1:0]  take_src,
  input logic [ADDR_W-1:0] take_addr,
  input logic              take_fast,
  input logic [CC_W-1:0]   take_cc,
  input logic [NUM_SRC-1:0] req_vec
);
  // R9: held entry stays put until accepted
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid && !take_ack |=> take_valid && $stable(take_addr) && $stable(take_src) && $stable(take_fast));

  // R9: acceptance drops the entry
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid && take_ack |=> !take_valid);

  // R3: a new entry appears only after a strobe
  a_r3_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take_valid) |-> $past(insn_bound));

  // R5: a masked normal request is never taken
  a_r5_norm_mask: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take_valid) && take_src == SRC_NORM |-> !$past(cc_in[NORM_MASK]));

  // R5: a masked fast request is never taken
  a_r5_fast_mask: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take_valid) && take_src == SRC_FAST |-> !$past(cc_in[FAST_MASK]));

  // R4: the fast request cannot win over a pending non-maskable request
  a_r4_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take_valid) && take_src == SRC_FAST |-> !$past(req_vec[SRC_NMI]));

  // R6: vector addresses stay in the top vector area and are even
  a_r6_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> take_addr[15:4] == 12'hFFF && !take_addr[0]);

  // R8: write-back never clears a bit of the sampled condition code
  a_r8_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take_valid) |-> ((take_cc & $past(cc_in)) == $past(cc_in)));

  // R7: fast flag only on fast entries
  a_r7_fast_flag: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid && take_fast |-> take_addr == 16'hFFF6);
endmodule

bind irq_vector_unit irq_vector_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .insn_bound (insn_bound),
  .cc_in      (cc_in),
  .take_ack   (take_ack),
  .take_valid (take_valid),
  .take_src   (take_src),
  .take_addr  (take_addr),
  .take_fast  (take_fast),
  .take_cc    (take_cc),
  .req_vec    (req_vec)
);

// File: tb/irq_vector_unit_test.sv
`timescale 1ns/1ps
module irq_vector_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi_req_n = 1'b1, irq_req_n = 1'b1, firq_req_n = 1'b1;
  logic [1:0]  swi_sel = 2'b00;
  logic        insn_bound = 1'b0;
  logic [7:0]  cc_in = 8'h00;
  logic        take_ack = 1'b0;
  logic        take_valid, take_fast;
  logic [2:0]  take_src;
  logic [15:0] take_addr;
  logic [7:0]  take_cc;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_vector_unit uut (
    .clk(clk), .rst_n(rst_n), .nmi_req_n(nmi_req_n), .irq_req_n(irq_req_n),
    .firq_req_n(firq_req_n), .swi_sel(swi_sel), .insn_bound(insn_bound),
    .cc_in(cc_in), .take_ack(take_ack), .take_valid(take_valid),
    .take_src(take_src), .take_addr(take_addr), .take_fast(take_fast),
    .take_cc(take_cc)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference: winning code, or 7 when nothing is eligible (R4, R5, R10).
  function automatic int ref_winner(bit nmi, bit irq, bit firq, logic [1:0] sw, logic [7:0] cc);
    if (nmi) return 1;
    if (sw == 2'b01) return 2;
    if (irq && cc[4] == 1'b0) return 3;
    if (firq && cc[6] == 1'b0) return 4;
    if (sw == 2'b10) return 5;
    if (sw == 2'b11) return 6;
    return 7;
  endfunction

  function automatic logic [15:0] ref_addr(int w);  // R6
    case (w)
      0: return 16'hFFFE; 1: return 16'hFFFC; 2: return 16'hFFFA;
      3: return 16'hFFF8; 4: return 16'hFFF6; 5: return 16'hFFF4;
      default: return 16'hFFF2;
    endcase
  endfunction

  function automatic logic [7:0] ref_cc(int w, logic [7:0] cc);  // R8
    if (w == 3) return cc | 8'h10;
    if (w == 5 || w == 6) return cc;
    return cc | 8'h50;
  endfunction

  task automatic accept();
    @(negedge clk) take_ack = 1'b1;
    @(negedge clk) take_ack = 1'b0;
    check("R9", "valid after ack", take_valid, 0);
  endtask

  task automatic trial(bit nmi, bit irq, bit firq, logic [1:0] sw, logic [7:0] cc, int hold);
    int w;
    @(negedge clk);
    nmi_req_n = ~nmi; irq_req_n = ~irq; firq_req_n = ~firq;
    repeat (3) @(negedge clk);
    insn_bound = 1'b1; swi_sel = sw; cc_in = cc;
    @(negedge clk);
    insn_bound = 1'b0; swi_sel = 2'b00;
    w = ref_winner(nmi, irq, firq, sw, cc);
    if (w == 7) begin
      check("R3", "no eligible source", take_valid, 0);
      return;
    end
    check("R4", "valid", take_valid, 1);
    check("R4", "source", take_src, w);
    check("R6", "address", take_addr, ref_addr(w));
    check("R7", "fast flag", take_fast, (w == 4));
    check("R8", "cc write-back", take_cc, ref_cc(w, cc));
    for (int k = 0; k < hold; k++) begin
      insn_bound = 1'b1; swi_sel = 2'b01; cc_in = ~cc;
      @(negedge clk);
      insn_bound = 1'b0; swi_sel = 2'b00;
      check("R9", "held source", take_src, w);
      check("R9", "held cc", take_cc, ref_cc(w, cc));
    end
    accept();
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    cc_in = 8'h81;
    repeat (3) @(negedge clk);
    check("R1", "valid in reset", take_valid, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "valid after reset", take_valid, 1);
    check("R1", "source", take_src, 0);
    check("R1", "address", take_addr, 16'hFFFE);
    check("R1", "fast", take_fast, 0);
    check("R1", "cc", take_cc, 8'hD1);
    accept();

    // R3: pending pins, no strobe
    nmi_req_n = 1'b0;
    repeat (5) @(negedge clk);
    check("R3", "no strobe no entry", take_valid, 0);
    nmi_req_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2: synchronizer latency
    irq_req_n = 1'b0; insn_bound = 1'b1; cc_in = 8'h00;
    @(negedge clk);
    check("R2", "one edge", take_valid, 0);
    @(negedge clk);
    check("R2", "two edges", take_valid, 0);
    @(negedge clk);
    insn_bound = 1'b0;
    check("R2", "three edges", take_valid, 1);
    check("R2", "source", take_src, 3);
    accept();
    irq_req_n = 1'b1;

    // Directed corners
    trial(1, 1, 1, 2'b11, 8'h50, 1);   // R5 nmi ignores masks
    trial(0, 1, 1, 2'b00, 8'h10, 1);   // R5 irq masked, firq wins
    trial(0, 1, 1, 2'b00, 8'h50, 0);   // R5 all masked
    trial(0, 1, 0, 2'b01, 8'h00, 1);   // R10 sw1 over irq
    trial(0, 0, 1, 2'b10, 8'h00, 0);   // R4 firq over sw2
    trial(0, 0, 0, 2'b11, 8'hFF, 1);   // R10 sw3 ignores masks
    trial(0, 0, 0, 2'b10, 8'h3C, 1);   // R8 sw2 leaves cc
    trial(0, 0, 1, 2'b00, 8'h00, 2);   // R7 fast entry

    for (int n = 0; n < 300; n++) begin
      logic [31:0] r;
      r = $urandom;
      trial(r[0] & r[1], r[2], r[3], r[5:4], r[15:8], int'(r[17:16]));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule